// File: doc/BRIEF.md
# Mode-3 SPI Register Target with One-Frame Read Latency

This block is a serial target that connects an external SPI controller to a bank of 32-bit registers inside the chip. SCLK idles high. MOSI is sampled on SCLK rising edges and MISO is updated on SCLK falling edges. Every frame is a command byte followed by a 32-bit word, sent least significant bit first. The low seven bits of the command byte give the register address and the eighth bit gives the direction. The frame is only acted upon when chip select goes high again.

Reads are pipelined. A read frame only records which register is wanted. That register is fetched when the next frame opens, and it is shifted out on MISO during that next frame. Writes become a single-cycle write strobe toward the register bank once the frame closes. All SPI inputs are brought into the system clock domain through synchronisers, and every edge is detected there. The system clock must run at least ten times faster than SCLK. The maximum SCLK rate is 10 MHz.

Top module: `spi_pipe_target`

## Requirements
- R1: Received bit k of a frame (k counted from 0, in arrival order) lands at frame bit k. Bits 6:0 are the register address, bit 7 selects the operation (1 = read, 0 = write) and bits 39:8 are the data word. So 0x8C reads register 0x0C and 0x0C writes it.
- R2: A complete write frame gives exactly one `reg_wr_en` pulse of one clock, carrying the frame's address and data. The pulse comes after CS_N has risen.
- R3: A complete read frame makes its address the pending read pointer. The register at that pointer is returned in the data phase of the following frame.
- R4: MISO stays 0 during the 8 command bits. During the 32 data bits it carries the returned word, least significant bit first. MISO only changes after an SCLK falling edge, so it can be sampled at the next rising edge.
- R5: Until a complete read frame has been accepted after reset, the returned word is all zeros and no `reg_rd_en` is issued.
- R6: The 32 data bits of a read frame are ignored: no write strobe results, whatever their value.
- R7: A frame with fewer than 40 SCLK rising edges before CS_N rises is dropped. It gives no write strobe and leaves the pending read pointer as it was.
- R8: The returned word is fetched at the falling edge of CS_N. A write to the same register carried by that frame does not alter the word being shifted out.
- R9: SCLK rising edges past the 40th in a frame are ignored. The first 40 bits are the ones committed.
- R10: MISO keeps driving its last value while CS_N is high.
- R11: `reg_rd_en` is a single-cycle pulse shortly after CS_N falls, issued only when a read pointer is pending. It never coincides with `reg_wr_en`.
- R12: During and right after reset, MISO, `reg_wr_en` and `reg_rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller, always driven |
| reg_wr_en | output | 1 | One-cycle write strobe to the register bank |
| reg_rd_en | output | 1 | One-cycle read strobe to the register bank |
| reg_addr | output | ADDR_W | Register address for either strobe |
| reg_wdata | output | DATA_W | Write data, valid with reg_wr_en |
| reg_rdata | input | DATA_W | Read data, valid in the cycle reg_rd_en is high |

## Verification
Every SPI input passes through two synchroniser flops and one edge register. An SCLK falling edge therefore shows up on MISO at the third rising clock edge after it. A CS_N rise raises `reg_wr_en` at the third edge, and a CS_N fall raises `reg_rd_en` at the third edge. The bench holds each SCLK half-period for ten clocks and samples MISO just before it raises SCLK, which is well after the update. Strobe counts, the last write address and data, and the stored registers are all checked twenty clocks after CS_N rises, when every result from the closed frame has settled. The expected returned word for each frame comes from the bench's own register model and its own record of the pending read pointer.

// File: rtl/spi_pipe_pkg.sv
package spi_pipe_pkg;
  localparam int DEF_ADDR_W = 7;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_SYNC_STAGES = 2;

  // total bits in one frame: command (address + direction) then data
  function automatic int frame_bits(input int addr_w, input int data_w);
    return addr_w + 1 + data_w;
  endfunction
endpackage

// File: rtl/spi_pipe_sync.sv
module spi_pipe_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_pipe_rx.sv
module spi_pipe_rx #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame,
  output logic               full
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  assign full  = (cnt_q == LAST);
  assign frame = frame_q;

  always_comb begin
    frame_d = frame_q;
    cnt_d   = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (shift_en && !full) begin
      // first bit received ends up at bit 0 once the frame is full
      frame_d = {bit_in, frame_q[FRAME_W-1:1]};
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/spi_pipe_tx.sv
module spi_pipe_tx #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift_en,
  output logic              miso
);
  localparam int FRAME_W = CMD_W + DATA_W;

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               miso_q, miso_d;

  always_comb begin
    sh_d   = sh_q;
    miso_d = miso_q;
    if (load) begin
      // zeros line up with the command phase, the word with the data phase
      sh_d = {load_word, {CMD_W{1'b0}}};
    end else if (shift_en) begin
      miso_d = sh_q[0];
      sh_d   = {1'b0, sh_q[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      miso_q <= miso_d;
    end
  end

  assign miso = miso_q;
endmodule

// File: rtl/spi_pipe_target.sv
module spi_pipe_target #(
  parameter int ADDR_W      = spi_pipe_pkg::DEF_ADDR_W,
  parameter int DATA_W      = spi_pipe_pkg::DEF_DATA_W,
  parameter int SYNC_STAGES = spi_pipe_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CMD_W   = ADDR_W + 1;
  localparam int FRAME_W = spi_pipe_pkg::frame_bits(ADDR_W, DATA_W);

  // ---- input synchronisation and edge detection ----
  logic sclk_s, cs_s, mosi_s;
  logic sclk_d, cs_d;

  spi_pipe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_sclk, spi_cs_n, spi_mosi}),
    .dout ({sclk_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  logic sclk_rise, sclk_fall, cs_fall, cs_rise;
  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
  assign cs_fall   = ~cs_s & cs_d;
  assign cs_rise   = cs_s & ~cs_d;

  // ---- receive path ----
  logic [FRAME_W-1:0] rx_frame;
  logic               rx_full;

  spi_pipe_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cs_fall),
    .shift_en(sclk_rise),
    .bit_in  (mosi_s),
    .frame   (rx_frame),
    .full    (rx_full)
  );

  logic [ADDR_W-1:0] f_addr;
  logic              f_rd;
  logic [DATA_W-1:0] f_data;
  logic              commit;
  assign f_addr = rx_frame[ADDR_W-1:0];
  assign f_rd   = rx_frame[ADDR_W];
  assign f_data = rx_frame[FRAME_W-1:CMD_W];
  assign commit = cs_rise & rx_full;

  // ---- control: next state ----
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_vld_q, ptr_vld_d;
  logic              wr_q, wr_d, rd_q, rd_d, load_q, load_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    ptr_d     = ptr_q;
    ptr_vld_d = ptr_vld_q;
    wr_d      = 1'b0;
    rd_d      = 1'b0;
    load_d    = cs_fall;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    if (cs_fall) begin
      rd_d   = ptr_vld_q;
      addr_d = ptr_q;
    end
    if (commit) begin
      if (f_rd) begin
        ptr_d     = f_addr;
        ptr_vld_d = 1'b1;
      end else begin
        wr_d    = 1'b1;
        addr_d  = f_addr;
        wdata_d = f_data;
      end
    end
  end

  // ---- control: registers ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      ptr_vld_q <= 1'b0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      load_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      ptr_q     <= ptr_d;
      ptr_vld_q <= ptr_vld_d;
      wr_q      <= wr_d;
      rd_q      <= rd_d;
      load_q    <= load_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
    end
  end

  // ---- transmit path ----
  logic [DATA_W-1:0] tx_word;
  assign tx_word = rd_q ? reg_rdata : '0;

  spi_pipe_tx #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_q),
    .load_word(tx_word),
    .shift_en (sclk_fall),
    .miso     (spi_miso)
  );

  assign reg_wr_en = wr_q;
  assign reg_rd_en = rd_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
endmodule

// File: rtl/spi_pipe_target_chk.sv
module spi_pipe_target_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_miso,
  input logic reg_wr_en,
  input logic reg_rd_en
);
  // R11
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R2
  wr_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> spi_cs_n);

  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

  // R11
  rd_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> !spi_cs_n);

  // R4
  miso_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso) |-> !spi_sclk);
endmodule

bind spi_pipe_target spi_pipe_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n),
  .spi_miso (spi_miso),
  .reg_wr_en(reg_wr_en),
  .reg_rd_en(reg_rd_en)
);

// File: tb/tb_spi_pipe_target.sv
module tb_spi_pipe_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b1;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic        reg_wr_en, reg_rd_en;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;   // 200 MHz

  spi_pipe_target dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // register bank model
  logic [31:0] mem [128];
  logic        mem_init = 1'b1;
  assign reg_rdata = mem[reg_addr];

  int          wr_cnt = 0, rd_cnt = 0;
  logic [6:0]  last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;

  always @(negedge clk) begin
    if (mem_init) begin
      for (int k = 0; k < 128; k++) mem[k] <= 32'h1000_0000 + 32'(k);
    end else if (reg_wr_en) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (reg_wr_en) begin
      wr_cnt       <= wr_cnt + 1;
      last_wr_addr <= reg_addr;
      last_wr_data <= reg_wdata;
    end
    if (reg_rd_en) rd_cnt <= rd_cnt + 1;
  end

  int errors = 0, checks = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one frame; bits past 40 are driven as ones
  task automatic run_frame(input logic [7:0] cmd, input logic [31:0] data,
                           input int nbits, output logic [31:0] got);
    logic [39:0] fv;
    fv  = {data, cmd};
    got = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sclk = 1'b0;
      spi_mosi = (i < 40) ? fv[i] : 1'b1;
      repeat (10) @(negedge clk);
      if (i >= 8 && i < 40) got[i-8] = spi_miso;
      spi_sclk = 1'b1;
      repeat (10) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // {command, data, expected returned word}
  localparam logic [71:0] VEC [8] = '{
    {8'h0C, 32'h0000_000A, 32'h0000_0000},
    {8'h8C, 32'h0000_0000, 32'h0000_0000},
    {8'h85, 32'h0000_0000, 32'h0000_000A},
    {8'h05, 32'hDEAD_BEEF, 32'h1000_0005},
    {8'h85, 32'hFFFF_FFFF, 32'hDEAD_BEEF},
    {8'h7F, 32'h1234_5678, 32'hDEAD_BEEF},
    {8'hFF, 32'h0000_0000, 32'hDEAD_BEEF},
    {8'h00, 32'hCAFE_F00D, 32'h1234_5678}
  };

  bit done = 0;

  initial begin
    logic [31:0] got;
    int          wr0, rd0;
    bit          ptr_vld;
    ptr_vld = 0;
    repeat (4) @(negedge clk);
    mem_init = 1'b0;
    rst_n    = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 miso", 32'(spi_miso), 32'h0);
    chk("R12 strobes", {30'h0, reg_wr_en, reg_rd_en}, 32'h0);

    foreach (VEC[v]) begin
      wr0 = wr_cnt;
      rd0 = rd_cnt;
      run_frame(VEC[v][71:64], VEC[v][63:32], 40, got);
      // R3 R4 R5 R8: returned word
      chk("R3/R4 returned word", got, VEC[v][31:0]);
      chk("R11 read strobes", 32'(rd_cnt - rd0), ptr_vld ? 32'd1 : 32'd0);
      if (VEC[v][71]) begin
        chk("R6 no write on read", 32'(wr_cnt - wr0), 32'd0);
        ptr_vld = 1;
      end else begin
        chk("R2 one write", 32'(wr_cnt - wr0), 32'd1);
        chk("R1 address", 32'(last_wr_addr), 32'(VEC[v][70:64]));
        chk("R1 data", last_wr_data, VEC[v][63:32]);
      end
    end

    // R7: short frames are dropped
    wr0 = wr_cnt;
    run_frame(8'h83, 32'h0, 20, got);
    run_frame(8'h01, 32'h55AA_55AA, 39, got);
    chk("R7 short write dropped", 32'(wr_cnt - wr0), 32'd0);
    chk("R7 register untouched", mem[1], 32'h1000_0001);
    run_frame(8'h02, 32'h0000_0001, 40, got);
    chk("R7 pointer kept", got, 32'h1234_5678);

    // R9: bits beyond 40 ignored
    run_frame(8'h03, 32'h0BAD_F00D, 48, got);
    chk("R9 long frame address", 32'(last_wr_addr), 32'h3);
    chk("R9 long frame data", last_wr_data, 32'h0BAD_F00D);

    // R10: MISO held after CS rises
    run_frame(8'h85, 32'h0, 40, got);
    run_frame(8'h85, 32'h0, 40, got);
    chk("R3 repeated read", got, 32'hDEAD_BEEF);
    repeat (40) @(negedge clk);
    chk("R10 miso held", 32'(spi_miso), 32'h1);

    // R12 / R5 after a second reset
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 miso in reset", 32'(spi_miso), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd0 = rd_cnt;
    run_frame(8'h8C, 32'h0, 40, got);
    chk("R5 zeros after reset", got, 32'h0);
    chk("R5 no read strobe", 32'(rd_cnt - rd0), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule